// File: doc/BRIEF.md
# Configurable MCU-Mapped I/O Port

An eight-pin general-purpose port whose behaviour a microcontroller sets at run time through a small window of memory-mapped registers. Every pin is configured on its own. For its output it picks one of four drive sources: the data-out register, a latched address bit, a logic macrocell output, or an external chip-select line. The pin's tri-state driver is turned on by the direction bit, or by an enable term from the programmable logic on pins that have such a term.

Each pin also has an input capture cell. The cell can pass the pad level straight through, act as a transparent latch, or act as an edge-triggered register. Its enable comes from the address strobe or from a per-pin logic-array clock term. The captured values go out toward the programmable logic. The MCU can read them back, and it can also read the raw pad levels, the macrocell outputs and every writable register, with one source on the read bus at a time.

The logic array and the address decoder are not part of this block. Their outputs arrive as plain inputs. The capture cell works from the port clock: latch transparency is combinational, the held value is refreshed on each clock edge while the enable is high, and enable edges are detected at the clock.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, all pins are inputs (pad_oe_o = 0). Every mux select is source 0, the data-out register is 0, every capture cell is in direct mode, and every writable register reads back 0.
- R2: A write with cs_i and wr_i high stores wdata_i at the clock edge. Writable offsets are 0 direction, 1 select low bits, 2 select high bits, 3 data-out, 4 capture-mode low bits, 5 capture-mode high bits, and 6 capture-clock select. Each one reads back what was written. Offsets 7 and 11 to 15 read 0.
- R3: rdata_o is 0 unless cs_i and rd_i are both high. A write strobe with cs_i low changes no register.
- R4: For pin i, the source code {select-high[i], select-low[i]} picks what drives pad_o[i]: 0 selects the data-out bit, 1 selects adr_lat_i[i], 2 selects mc_i[i], and 3 selects ecs_i[i].
- R5: pad_oe_o[i] is the direction bit ORed with pla_oe_i[i] on pins whose bit is set in parameter OE_TERM_MASK (default 8'hF0). On the other pins the direction bit alone controls the driver and pla_oe_i is ignored.
- R6: Capture mode code {mode-high[i], mode-low[i]} = 0 (and the spare code 3) is direct: cap_o[i] follows pad_i[i] in the same cycle.
- R7: Mode code 1 is a latch. cap_o[i] follows pad_i[i] while the pin's enable is high, and holds the value taken at the last clock edge with the enable high while the enable is low.
- R8: Mode code 2 is an edge register. At a clock edge where the pin's enable is high and was low at the previous edge, pad_i[i] is captured, and it appears on cap_o[i] after that edge. An enable that stays high captures nothing more.
- R9: Capture-clock select bit i = 0 takes the pin's enable from strobe_i. A value of 1 takes it from pla_ck_i[i].
- R10: Read-only offsets 8 (captured inputs cap_o), 9 (raw pad_i) and 10 (macrocell outputs mc_i) return live values. Writes to them have no effect.
- R11: A read and a write to the same offset in one cycle return the old register value in that cycle. The new value is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Register window select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when not reading |
| adr_lat_i | input | 8 | Latched address bits, mux source 1 |
| mc_i | input | 8 | Macrocell outputs, mux source 2 |
| ecs_i | input | 8 | External chip-selects, mux source 3 |
| pla_oe_i | input | 8 | Logic-array output-enable terms |
| pla_ck_i | input | 8 | Logic-array capture clock terms |
| strobe_i | input | 1 | Address strobe, shared capture enable |
| pad_i | input | 8 | Pad input levels |
| pad_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad tri-state enables |
| cap_o | output | 8 | Captured inputs toward the logic |

## Verification
A register write and an MCU read of the same offset can fall in one cycle. The bench provokes this by raising cs_i, wr_i and rd_i together on the data-out offset with new data. It judges rdata_o in that cycle against the old contents, and in the next cycle against the new contents. A capture-enable edge can also come from both enable sources in one run. The bench drives strobe_i and pla_ck_i separately with a mixed clock-select mask. It then checks that only the pins bound to the toggled source take the new pad value.

// File: rtl/cfg_io_port_pkg.sv
package cfg_io_port_pkg;
  localparam int ADDR_W = 4;
  localparam int NUM_WR_REGS = 7;

  localparam logic [ADDR_W-1:0] OFS_DIR    = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_SEL_LO = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_SEL_HI = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_CM_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_CM_HI  = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_CK_SEL = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_CAP    = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_PAD    = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_MC     = 4'd10;

  typedef enum logic [1:0] {SRC_DOUT, SRC_ADDR, SRC_MACRO, SRC_ECS} out_src_e;
  typedef enum logic [1:0] {CAP_DIRECT, CAP_LATCH, CAP_EDGE, CAP_SPARE} cap_mode_e;
endpackage

// File: rtl/cfg_io_port_regs.sv
module cfg_io_port_regs
  import cfg_io_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  sel_lo_o,
  output logic [WIDTH-1:0]  sel_hi_o,
  output logic [WIDTH-1:0]  dout_o,
  output logic [WIDTH-1:0]  cm_lo_o,
  output logic [WIDTH-1:0]  cm_hi_o,
  output logic [WIDTH-1:0]  ck_sel_o
);
  logic [NUM_WR_REGS-1:0][WIDTH-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else begin
      for (int r = 0; r < NUM_WR_REGS; r++) begin
        if (we_i && addr_i == ADDR_W'(r)) regs_q[r] <= wdata_i;
      end
    end
  end

  assign dir_o    = regs_q[OFS_DIR];
  assign sel_lo_o = regs_q[OFS_SEL_LO];
  assign sel_hi_o = regs_q[OFS_SEL_HI];
  assign dout_o   = regs_q[OFS_DOUT];
  assign cm_lo_o  = regs_q[OFS_CM_LO];
  assign cm_hi_o  = regs_q[OFS_CM_HI];
  assign ck_sel_o = regs_q[OFS_CK_SEL];

  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_DIR) |=> dir_o == $past(wdata_i));
  a_r2_dout_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_DOUT) |=> dout_o == $past(wdata_i));
  a_r3_dout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFS_DOUT) |=> $stable(dout_o));
endmodule

// File: rtl/cfg_io_port_pin.sv
module cfg_io_port_pin
  import cfg_io_port_pkg::*;
#(
  parameter bit HAS_TERM = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       dout_i,
  input  logic       adr_i,
  input  logic       mc_i,
  input  logic       ecs_i,
  input  logic       dir_i,
  input  logic       term_oe_i,
  input  logic [1:0] mode_i,
  input  logic       ck_sel_i,
  input  logic       strobe_i,
  input  logic       pla_ck_i,
  input  logic       pad_i,
  output logic       pad_o,
  output logic       oe_o,
  output logic       cap_o
);
  out_src_e  src;
  cap_mode_e mode;
  logic      en, en_q, cap_q;

  assign src  = out_src_e'(sel_i);
  assign mode = cap_mode_e'(mode_i);

  always_comb begin
    unique case (src)
      SRC_DOUT:  pad_o = dout_i;
      SRC_ADDR:  pad_o = adr_i;
      SRC_MACRO: pad_o = mc_i;
      default:   pad_o = ecs_i;
    endcase
  end

  // driver enable: OR with array term only where the pin owns one
  generate
    if (HAS_TERM) begin : g_term
      assign oe_o = dir_i | term_oe_i;
    end else begin : g_no_term
      logic unused_term;
      assign unused_term = term_oe_i;
      assign oe_o = dir_i;
      a_r5_dir_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dir_i && term_oe_i) |-> !oe_o);
    end
  endgenerate

  assign en = ck_sel_i ? pla_ck_i : strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cap_q <= 1'b0;
    end else begin
      en_q <= en;
      unique case (mode)
        CAP_LATCH: if (en) cap_q <= pad_i;
        CAP_EDGE:  if (en && !en_q) cap_q <= pad_i;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      CAP_LATCH: cap_o = en ? pad_i : cap_q;
      CAP_EDGE:  cap_o = cap_q;
      default:   cap_o = pad_i;
    endcase
  end

  a_r7_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CAP_LATCH && !en && $past(mode == CAP_LATCH && !en)) |-> $stable(cap_o));
  a_r8_edge_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CAP_EDGE && en && !en_q) |=> (mode != CAP_EDGE || cap_o == $past(pad_i)));
  a_r8_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CAP_EDGE && !(en && !en_q)) |=> (mode != CAP_EDGE || $stable(cap_o)));
endmodule

// File: rtl/cfg_io_port_rdmux.sv
module cfg_io_port_rdmux
  import cfg_io_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  sel_lo_i,
  input  logic [WIDTH-1:0]  sel_hi_i,
  input  logic [WIDTH-1:0]  dout_i,
  input  logic [WIDTH-1:0]  cm_lo_i,
  input  logic [WIDTH-1:0]  cm_hi_i,
  input  logic [WIDTH-1:0]  ck_sel_i,
  input  logic [WIDTH-1:0]  cap_i,
  input  logic [WIDTH-1:0]  pad_i,
  input  logic [WIDTH-1:0]  mc_i,
  output logic [WIDTH-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      unique case (addr_i)
        OFS_DIR:    rdata_o = dir_i;
        OFS_SEL_LO: rdata_o = sel_lo_i;
        OFS_SEL_HI: rdata_o = sel_hi_i;
        OFS_DOUT:   rdata_o = dout_i;
        OFS_CM_LO:  rdata_o = cm_lo_i;
        OFS_CM_HI:  rdata_o = cm_hi_i;
        OFS_CK_SEL: rdata_o = ck_sel_i;
        OFS_CAP:    rdata_o = cap_i;
        OFS_PAD:    rdata_o = pad_i;
        OFS_MC:     rdata_o = mc_i;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import cfg_io_port_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] OE_TERM_MASK = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  adr_lat_i,
  input  logic [WIDTH-1:0]  mc_i,
  input  logic [WIDTH-1:0]  ecs_i,
  input  logic [WIDTH-1:0]  pla_oe_i,
  input  logic [WIDTH-1:0]  pla_ck_i,
  input  logic              strobe_i,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  pad_o,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  cap_o
);
  logic [WIDTH-1:0] dir, sel_lo, sel_hi, dout, cm_lo, cm_hi, ck_sel;
  logic we, re;

  assign we = cs_i & wr_i;
  assign re = cs_i & rd_i;

  cfg_io_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .addr_i, .wdata_i,
    .dir_o(dir), .sel_lo_o(sel_lo), .sel_hi_o(sel_hi), .dout_o(dout),
    .cm_lo_o(cm_lo), .cm_hi_o(cm_hi), .ck_sel_o(ck_sel)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    cfg_io_port_pin #(.HAS_TERM(OE_TERM_MASK[i])) u_pin (
      .clk_i, .rst_ni,
      .sel_i({sel_hi[i], sel_lo[i]}),
      .dout_i(dout[i]), .adr_i(adr_lat_i[i]), .mc_i(mc_i[i]), .ecs_i(ecs_i[i]),
      .dir_i(dir[i]), .term_oe_i(pla_oe_i[i]),
      .mode_i({cm_hi[i], cm_lo[i]}), .ck_sel_i(ck_sel[i]),
      .strobe_i, .pla_ck_i(pla_ck_i[i]), .pad_i(pad_i[i]),
      .pad_o(pad_o[i]), .oe_o(pad_oe_o[i]), .cap_o(cap_o[i])
    );
  end

  cfg_io_port_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .re_i(re), .addr_i,
    .dir_i(dir), .sel_lo_i(sel_lo), .sel_hi_i(sel_hi), .dout_i(dout),
    .cm_lo_i(cm_lo), .cm_hi_i(cm_hi), .ck_sel_i(ck_sel),
    .cap_i(cap_o), .pad_i, .mc_i, .rdata_o
  );

  a_r3_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> rdata_o == '0);
  a_r11_old_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == OFS_DOUT) |-> rdata_o == dout);
  a_r5_dir_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir == '1) |-> pad_oe_o == '1);
endmodule

// File: tb/cfg_io_port_tb.sv
module cfg_io_port_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       cs_i = 0, rd_i = 0, wr_i = 0, strobe_i = 0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0, adr_lat_i = '0, mc_i = '0, ecs_i = '0;
  logic [7:0] pla_oe_i = '0, pla_ck_i = '0, pad_i = '0;
  logic [7:0] rdata_o, pad_o, pad_oe_o, cap_o;
  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  cfg_io_port u_dut (.*);

  // {offset, write data, expected readback}
  localparam logic [19:0] WR_VEC [8] = '{
    {4'd0, 8'h81, 8'h81}, {4'd1, 8'h42, 8'h42}, {4'd2, 8'h24, 8'h24},
    {4'd3, 8'h18, 8'h18}, {4'd4, 8'hC3, 8'hC3}, {4'd5, 8'h3C, 8'h3C},
    {4'd6, 8'h99, 8'h99}, {4'd7, 8'hFF, 8'h00}
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 0; wr_i = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; rd_i = 1; addr_i = a;
    #5 d = rdata_o;
    cs_i = 0; rd_i = 0;
  endtask

  function automatic logic [7:0] mux_exp(logic [7:0] lo, hi, dout, adr, mc, ecs);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      case ({hi[i], lo[i]})
        2'd0: r[i] = dout[i];
        2'd1: r[i] = adr[i];
        2'd2: r[i] = mc[i];
        default: r[i] = ecs[i];
      endcase
    end
    return r;
  endfunction

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    pad_i = 8'h5A;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    #5;
    check("R1 pad_oe", pad_oe_o, 8'h00);
    check("R1 pad_o", pad_o, 8'h00);
    check("R1 cap direct", cap_o, 8'h5A);
    for (int r = 0; r < 7; r++) begin
      rd(4'(r), d);
      check("R1 reg zero", d, 8'h00);
    end

    // R2 table walk
    for (int v = 0; v < 8; v++) begin
      wr(WR_VEC[v][19:16], WR_VEC[v][15:8]);
      rd(WR_VEC[v][19:16], d);
      check("R2 readback", d, WR_VEC[v][7:0]);
    end
    wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd6, 8'h00); wr(4'd0, 8'h00);

    // R3 gating
    @(negedge clk_i); cs_i = 0; wr_i = 1; addr_i = 4'd0; wdata_i = 8'hFF;
    @(negedge clk_i); wr_i = 0;
    rd(4'd0, d);
    check("R3 write without cs", d, 8'h00);
    @(negedge clk_i); cs_i = 1; rd_i = 0; addr_i = 4'd3;
    #5 check("R3 no read strobe", rdata_o, 8'h00);
    cs_i = 0;

    // R4 mux
    adr_lat_i = 8'h3C; mc_i = 8'hF0; ecs_i = 8'h0F;
    wr(4'd3, 8'hA5); wr(4'd1, 8'hCC); wr(4'd2, 8'hF0);
    #5 check("R4 mux mixed", pad_o, mux_exp(8'hCC, 8'hF0, 8'hA5, 8'h3C, 8'hF0, 8'h0F));
    wr(4'd1, 8'h55); wr(4'd2, 8'h33);
    #5 check("R4 mux alt", pad_o, mux_exp(8'h55, 8'h33, 8'hA5, 8'h3C, 8'hF0, 8'h0F));

    // R5 enable
    wr(4'd0, 8'h03);
    pla_oe_i = 8'hFF;
    #5 check("R5 term on", pad_oe_o, 8'hF3);
    pla_oe_i = 8'h0F;
    #5 check("R5 term ignored", pad_oe_o, 8'h03);
    wr(4'd0, 8'h00); pla_oe_i = 8'h00;
    #5 check("R5 all off", pad_oe_o, 8'h00);

    // R6 direct
    pad_i = 8'hA5;
    #5 check("R6 direct", cap_o, 8'hA5);

    // R7 latch via strobe
    wr(4'd4, 8'hFF); wr(4'd5, 8'h00);
    @(negedge clk_i); strobe_i = 1; pad_i = 8'h11;
    #5 check("R7 transparent", cap_o, 8'h11);
    pad_i = 8'h22;
    #1 check("R7 follows", cap_o, 8'h22);
    @(negedge clk_i); strobe_i = 0; pad_i = 8'h33;
    #5 check("R7 hold", cap_o, 8'h22);
    @(negedge clk_i); #5 check("R7 hold later", cap_o, 8'h22);

    // R8 edge register
    wr(4'd4, 8'h00); wr(4'd5, 8'hFF);
    @(negedge clk_i); pad_i = 8'h44;
    @(negedge clk_i); strobe_i = 1;
    @(negedge clk_i); #5 check("R8 capture", cap_o, 8'h44);
    pad_i = 8'h55;
    @(negedge clk_i); #5 check("R8 no recapture", cap_o, 8'h44);

    // R9 clock source per pin: high nibble from array clock
    wr(4'd6, 8'hF0);
    @(negedge clk_i); strobe_i = 0; pad_i = 8'h66;
    @(negedge clk_i); strobe_i = 1;
    @(negedge clk_i); #5 check("R9 strobe pins", cap_o, 8'h46);
    pad_i = 8'h77; pla_ck_i = 8'hFF;
    @(negedge clk_i); #5 check("R9 array pins", cap_o, 8'h76);

    // R10 read-only offsets
    mc_i = 8'h9C;
    rd(4'd8, d); check("R10 cap read", d, 8'h76);
    rd(4'd9, d); check("R10 pad read", d, 8'h77);
    wr(4'd9, 8'h00);
    rd(4'd9, d); check("R10 pad write ignored", d, 8'h77);
    rd(4'd10, d); check("R10 mc read", d, 8'h9C);

    // R11 write and read same cycle
    @(negedge clk_i); cs_i = 1; wr_i = 1; rd_i = 1; addr_i = 4'd3; wdata_i = 8'h6E;
    #5 check("R11 old value", rdata_o, 8'hA5);
    @(negedge clk_i); wr_i = 0;
    #5 check("R11 new value", rdata_o, 8'h6E);
    cs_i = 0; rd_i = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule